// File: doc/BRIEF.md
# Processor Local Bus Register Slave

This block is a synchronous target on a processor-style local bus. On each rising clock edge it looks for a transfer start. It then decodes the direction, an 18-bit low-order address and a two-bit size code, and performs a byte, half-word or word access to a small internal register array. Every access ends with one of three active-low responses, each lasting one cycle. A normal acknowledge reports that write data was taken or that read data is on the bus. A transfer-error acknowledge reports an illegal size, a misaligned or out-of-range address, or a write whose byte-lane parity is wrong. A retry asks the master to give up the bus and repeat the cycle.

Every byte lane carries odd parity. The slave checks the parity of the lanes a write enables and generates parity for all four lanes of read data. A master may open a word burst by holding the burst input low at the start. It then keeps the burst-data-in-progress input high for each further beat it wants, up to four beats in all, with the word address advancing by one (byte address +4) each beat. Dropping that input ends the burst early.

The bus has no valid/ready pair. The one handshake is the response pulse: the master keeps its start, address and data stable for the edge it wants sampled and waits for a response. The slave never stalls a beat. It answers every sampled beat on the next cycle, so the only back-pressure it can apply is the retry, driven from the busy input.

Top module: `lbus_slave`

## Requirements
- R1: While and after reset, ack_n_o, tea_n_o and retry_n_o are high, rdata_o is zero, rpar_o is 4'b1111, and every register word reads back as zero.
- R2: A start_i sampled high on a rising edge (with no burst active) produces exactly one low response pulse on ack_n_o, tea_n_o or retry_n_o, lasting one cycle and visible in the cycle after that edge. rd_wr_i high selects a read and low selects a write.
- R3: size_i 2'b00 is a word, 2'b01 a byte and 2'b10 a half-word. The byte at offset k = addr_i[1:0] travels on wdata_i[31-8k -: 8]. The half-word at offset 0 uses bits [31:16] and the one at offset 2 uses bits [15:0]. A write changes only the enabled lanes of the word addr_i[17:2].
- R4: An acknowledged read places the whole addressed word on rdata_o in the acknowledge cycle, whatever the size. In every other cycle rdata_o is zero.
- R5: rpar_o[g] is odd parity over rdata_o[8g+7:8g], so the nine bits together hold an odd number of ones.
- R6: A write with wrong odd parity on any enabled lane (wpar_i[g] covers wdata_i[8g+7:8g]) is answered with tea_n_o and writes nothing. A parity error on a lane the size does not enable is ignored.
- R7: size_i 2'b11, a half-word at an odd address, a word whose addr_i[1:0] is not zero, and a word index addr_i[17:2] of NUM_WORDS or more are each answered with tea_n_o. Such an access writes nothing and returns zero data.
- R8: busy_i high at a transfer start is answered with retry_n_o and no access is made. Retry takes priority over every error.
- R9: A start with burst_n_i low and word size that is acknowledged opens a burst. On each later edge where bdip_i is high, one more beat runs at the next word index, in the same direction as the first beat. After MAX_BEATS (4) beats no further response comes, even if bdip_i stays high.
- R10: bdip_i low on an edge while a burst is open ends the burst with no response on that edge.
- R11: A burst start with a size other than word is answered with tea_n_o and opens no burst. A burst beat that hits an error is answered with tea_n_o and ends the burst.
- R12: start_i asserted while a burst is open is ignored, as are the address, size and direction presented with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transfer start, sampled on one edge |
| rd_wr_i | input | 1 | 1 = read, 0 = write |
| addr_i | input | 18 | Low-order byte address |
| size_i | input | 2 | Transfer size code |
| burst_n_i | input | 1 | Low at start to request a burst |
| bdip_i | input | 1 | High to request the next burst beat |
| busy_i | input | 1 | Forces a retry on a new transfer |
| wdata_i | input | 32 | Write data |
| wpar_i | input | 4 | Write lane parity (odd) |
| rdata_o | output | 32 | Read data, valid in the acknowledge cycle |
| rpar_o | output | 4 | Read lane parity (odd) |
| ack_n_o | output | 1 | Active-low transfer acknowledge |
| tea_n_o | output | 1 | Active-low transfer error acknowledge |
| retry_n_o | output | 1 | Active-low retry request |

## Verification
The bench aims at lane placement: a byte or half-word write that picked the wrong lanes would corrupt neighbouring bytes, and the read-back compare would show it. It also targets parity on disabled lanes. A slave that checked all four lanes would raise a false error on a correct byte write, and one that checked no lanes would let a corrupted byte reach the array. For bursts it drives a held burst-data-in-progress input past four beats, an early drop after two beats, a burst that runs off the end of the array and a start injected mid-burst. A slave with a wrong beat counter, a wrong stop rule or a wrong idle rule would give an extra acknowledge or write to a stray word. It also pairs busy with an illegal size, to catch a response priority that lets the error win over the retry.

// File: rtl/lbus_slave_pkg.sv
package lbus_slave_pkg;
  localparam int LANES = 4;

  typedef enum logic [1:0] {
    SZ_WORD = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_HALF = 2'b10,
    SZ_BAD  = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/lbus_size_decode.sv
module lbus_size_decode
  import lbus_slave_pkg::*;
(
  input  logic [1:0]       size_i,
  input  logic [1:0]       offset_i,
  output logic [LANES-1:0] lane_en_o,
  output logic             bad_o
);
  // lane_en_o[g] enables data bits [8g+7:8g]; byte offset 0 sits on the top lane
  always_comb begin
    lane_en_o = '0;
    bad_o     = 1'b0;
    unique case (xfer_size_e'(size_i))
      SZ_WORD: begin
        lane_en_o = '1;
        bad_o     = (offset_i != 2'b00);
      end
      SZ_BYTE: lane_en_o = 4'b1000 >> offset_i;
      SZ_HALF: begin
        lane_en_o = offset_i[1] ? 4'b0011 : 4'b1100;
        bad_o     = offset_i[0];
      end
      default: bad_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/lbus_lane_parity.sv
module lbus_lane_parity #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] data_i,
  output logic [LANES-1:0]   odd_par_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign odd_par_o[g] = ~^data_i[8*g +: 8];
  end
endmodule

// File: rtl/lbus_regfile.sv
module lbus_regfile #(
  parameter int NUM_WORDS = 16,
  parameter int LANES     = 4,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int DATA_W   = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [LANES-1:0]  lane_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem [NUM_WORDS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= '0;
    end else if (we_i) begin
      for (int l = 0; l < LANES; l++)
        if (lane_en_i[l]) mem[idx_i][8*l +: 8] <= wdata_i[8*l +: 8];
    end
  end

  assign rdata_o = mem[idx_i];
endmodule

// File: rtl/lbus_slave.sv
module lbus_slave
  import lbus_slave_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int NUM_WORDS = 16,
  parameter int MAX_BEATS = 4,
  localparam int DATA_W   = 8 * LANES,
  localparam int WADDR_W  = ADDR_W - 2,
  localparam int IDX_W    = $clog2(NUM_WORDS),
  localparam int BEAT_W   = $clog2(MAX_BEATS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              rd_wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  input  logic              burst_n_i,
  input  logic              bdip_i,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  wpar_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [LANES-1:0]  rpar_o,
  output logic              ack_n_o,
  output logic              tea_n_o,
  output logic              retry_n_o
);
  logic               in_burst_q, burst_rw_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [WADDR_W-1:0] baddr_q;

  logic               new_xfer, cont_beat, access, retry, err, ok, eff_rw, last_beat;
  logic [WADDR_W-1:0] eff_waddr;
  logic [1:0]         eff_off, eff_size;
  logic [LANES-1:0]   lane_en, wpar_gen;
  logic               size_bad, in_range, par_bad, burst_size_bad;
  logic [DATA_W-1:0]  rword;

  logic               ack_n_q, tea_n_q, retry_n_q;
  logic [DATA_W-1:0]  rdata_q;

  assign new_xfer  = start_i & ~in_burst_q;
  assign cont_beat = in_burst_q & bdip_i;
  assign access    = new_xfer | cont_beat;

  assign eff_waddr = new_xfer ? addr_i[ADDR_W-1:2] : baddr_q;
  assign eff_off   = new_xfer ? addr_i[1:0] : 2'b00;
  assign eff_size  = new_xfer ? size_i : SZ_WORD;
  assign eff_rw    = new_xfer ? rd_wr_i : burst_rw_q;

  lbus_size_decode u_dec (
    .size_i    (eff_size),
    .offset_i  (eff_off),
    .lane_en_o (lane_en),
    .bad_o     (size_bad)
  );

  lbus_lane_parity #(.LANES(LANES)) u_wpar (
    .data_i    (wdata_i),
    .odd_par_o (wpar_gen)
  );

  lbus_lane_parity #(.LANES(LANES)) u_rpar (
    .data_i    (rdata_q),
    .odd_par_o (rpar_o)
  );

  assign in_range       = ({1'b0, eff_waddr} < (WADDR_W+1)'(NUM_WORDS));
  assign par_bad        = ~eff_rw & (|(lane_en & (wpar_i ^ wpar_gen)));
  assign burst_size_bad = new_xfer & ~burst_n_i & (size_i != SZ_WORD);
  assign retry          = new_xfer & busy_i;
  assign err            = size_bad | ~in_range | par_bad | burst_size_bad;
  assign ok             = access & ~retry & ~err;
  assign last_beat      = (beat_q == BEAT_W'(MAX_BEATS - 2));

  lbus_regfile #(.NUM_WORDS(NUM_WORDS), .LANES(LANES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (ok & ~eff_rw),
    .lane_en_i (lane_en),
    .idx_i     (eff_waddr[IDX_W-1:0]),
    .wdata_i   (wdata_i),
    .rdata_o   (rword)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ack_n_q   <= 1'b1;
      tea_n_q   <= 1'b1;
      retry_n_q <= 1'b1;
      rdata_q   <= '0;
    end else begin
      ack_n_q   <= ~ok;
      tea_n_q   <= ~(access & ~retry & err);
      retry_n_q <= ~retry;
      rdata_q   <= (ok & eff_rw) ? rword : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_burst_q <= 1'b0;
      burst_rw_q <= 1'b0;
      beat_q     <= '0;
      baddr_q    <= '0;
    end else if (new_xfer) begin
      if (ok & ~burst_n_i) begin
        in_burst_q <= 1'b1;
        beat_q     <= '0;
        baddr_q    <= eff_waddr + 1'b1;
        burst_rw_q <= rd_wr_i;
      end
    end else if (in_burst_q) begin
      if (!bdip_i || !ok || last_beat) begin
        in_burst_q <= 1'b0;
      end else begin
        beat_q  <= beat_q + 1'b1;
        baddr_q <= baddr_q + 1'b1;
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign ack_n_o   = ack_n_q;
  assign tea_n_o   = tea_n_q;
  assign retry_n_o = retry_n_q;

  // R2
  one_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({~ack_n_o, ~tea_n_o, ~retry_n_o}) <= 1);

  // R8
  retry_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !in_burst_q && busy_i) |=> (!retry_n_o && ack_n_o && tea_n_o));

  // R7
  bad_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !in_burst_q && !busy_i && size_i == 2'b11) |=> !tea_n_o);

  // R10
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_burst_q && !bdip_i) |=> (ack_n_o && tea_n_o && !in_burst_q));

  // R9
  beat_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_burst_q |-> (int'(beat_q) <= MAX_BEATS - 2));
endmodule

// File: tb/test_lbus_slave.sv
module test_lbus_slave;
  localparam int NW = 16;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, rd_wr = 1'b0, burst_n = 1'b1, bdip = 1'b0, busy = 1'b0;
  logic [17:0] addr = '0;
  logic [1:0]  size = 2'b00;
  logic [31:0] wdata = '0;
  logic [3:0]  wpar = 4'hF;
  logic [31:0] rdata;
  logic [3:0]  rpar;
  logic        ack_n, tea_n, retry_n;

  int    n_cmp = 0, n_bad = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  lbus_slave #(.NUM_WORDS(NW)) i_lbus_slave (
    .clk(clk), .rst_n(rst_n), .start_i(start), .rd_wr_i(rd_wr), .addr_i(addr),
    .size_i(size), .burst_n_i(burst_n), .bdip_i(bdip), .busy_i(busy),
    .wdata_i(wdata), .wpar_i(wpar), .rdata_o(rdata), .rpar_o(rpar),
    .ack_n_o(ack_n), .tea_n_o(tea_n), .retry_n_o(retry_n)
  );

  function automatic logic [3:0] opar(logic [31:0] w);
    logic [3:0] p;
    for (int b = 0; b < 4; b++) p[b] = (($countones(w[8*b +: 8]) % 2) == 0);
    return p;
  endfunction

  // behavioural reference model
  logic [31:0] m_mem [NW];
  bit          m_burst, m_rw;
  int          m_beats, m_widx;
  logic        e_ack_n = 1'b1, e_tea_n = 1'b1, e_retry_n = 1'b1;
  logic [31:0] e_rdata = '0;

  always @(posedge clk) begin
    bit nw, ct, rty, er, rw;
    int widx, off, nbytes;
    logic [3:0] en;
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) m_mem[i] = 32'h0;
      m_burst = 0; m_beats = 0; m_widx = 0; m_rw = 0;
      e_ack_n = 1; e_tea_n = 1; e_retry_n = 1; e_rdata = 0;
    end else begin
      nw = start && !m_burst;
      ct = m_burst && bdip;
      e_ack_n = 1; e_tea_n = 1; e_retry_n = 1; e_rdata = 0;
      if (nw || ct) begin
        if (nw) begin
          widx = int'(addr) / 4; off = int'(addr) % 4; rw = rd_wr;
          nbytes = (size == 2'b00) ? 4 : (size == 2'b01) ? 1 : (size == 2'b10) ? 2 : 0;
        end else begin
          widx = m_widx; off = 0; rw = m_rw; nbytes = 4;
        end
        en = 4'b0; er = 0;
        if (nbytes == 0 || (off % nbytes) != 0) er = 1;
        else for (int k = off; k < off + nbytes; k++) en[3-k] = 1'b1;
        if (widx >= NW) er = 1;
        if (nw && !burst_n && nbytes != 4) er = 1;
        if (!rw)
          for (int b = 0; b < 4; b++)
            if (en[b] && ($countones({wdata[8*b +: 8], wpar[b]}) % 2) == 0) er = 1;
        rty = nw && busy;
        if (rty) e_retry_n = 0;
        else if (er) e_tea_n = 0;
        else begin
          e_ack_n = 0;
          if (rw) e_rdata = m_mem[widx];
          else for (int b = 0; b < 4; b++) if (en[b]) m_mem[widx][8*b +: 8] = wdata[8*b +: 8];
        end
        if (nw) begin
          if (!rty && !er && !burst_n) begin
            m_burst = 1; m_beats = 1; m_widx = widx + 1; m_rw = rw;
          end
        end else begin
          m_beats++; m_widx++;
          if (er || m_beats == 4) m_burst = 0;
        end
      end else if (m_burst && !bdip) begin
        m_burst = 0;
      end
    end
  end

  // compare on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_cmp++;
      if ({ack_n, tea_n, retry_n} !== {e_ack_n, e_tea_n, e_retry_n} ||
          rdata !== e_rdata || rpar !== opar(e_rdata)) begin
        n_bad++;
        $display("FAIL %s t=%0t act ack/tea/rty=%b%b%b data=%h par=%h exp %b%b%b data=%h par=%h",
                 tag, $time, ack_n, tea_n, retry_n, rdata, rpar,
                 e_ack_n, e_tea_n, e_retry_n, e_rdata, opar(e_rdata));
      end
    end
  end

  task automatic single(bit rw, logic [17:0] a, logic [1:0] sz, logic [31:0] d,
                        logic [3:0] pflip = 4'h0, bit bz = 0);
    @(negedge clk);
    start = 1; rd_wr = rw; addr = a; size = sz; burst_n = 1; bdip = 0; busy = bz;
    wdata = d; wpar = opar(d) ^ pflip;
    @(negedge clk);
    start = 0; busy = 0;
    @(negedge clk);
  endtask

  task automatic burst(bit rw, logic [17:0] a, logic [1:0] sz, int hold,
                       logic [31:0] base, bit inject = 0);
    @(negedge clk);
    start = 1; rd_wr = rw; addr = a; size = sz; burst_n = 0; bdip = 1;
    wdata = base; wpar = opar(base);
    for (int k = 1; k <= hold; k++) begin
      @(negedge clk);
      start = (inject && k == 1);
      if (inject && k == 1) begin addr = 18'd0; rd_wr = ~rw; size = 2'b01; end
      wdata = base + k * 32'h0101_0101; wpar = opar(wdata);
    end
    @(negedge clk);
    start = 0; bdip = 0; burst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired in %s", tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1: outputs while in reset
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({ack_n, tea_n, retry_n} !== 3'b111 || rdata !== 32'h0 || rpar !== 4'hF) begin
      n_bad++;
      $display("FAIL R1 reset act %b%b%b %h %h exp 111 00000000 f",
               ack_n, tea_n, retry_n, rdata, rpar);
    end
    rst_n = 1;
    single(1, 18'd8, 2'b00, 0);                       // R1 word reads zero

    tag = "R2";                                        // R2 R4 R5 word write/read
    single(0, 18'd4, 2'b00, 32'hA5C3_0F71);
    single(1, 18'd4, 2'b00, 0);

    tag = "R3";                                        // R3 byte lanes
    single(0, 18'd8,  2'b01, 32'h1100_0000);
    single(0, 18'd9,  2'b01, 32'h0022_0000);
    single(0, 18'd10, 2'b01, 32'h0000_3300);
    single(0, 18'd11, 2'b01, 32'hFFFF_FF44);
    single(1, 18'd9,  2'b01, 0);                        // R4 byte read returns word
    single(0, 18'd12, 2'b10, 32'hBEEF_0000);
    single(0, 18'd14, 2'b10, 32'h0000_CAFE);
    single(1, 18'd12, 2'b00, 0);
    single(0, 18'd4,  2'b10, 32'h1234_5678);           // R3 neighbour lanes kept
    single(1, 18'd4,  2'b00, 0);

    tag = "R7";
    single(0, 18'd13, 2'b10, 32'h0);                    // R7 odd half-word
    single(0, 18'd6,  2'b00, 32'h0);                    // R7 word offset 2
    single(0, 18'd16, 2'b11, 32'h5);                    // R7 size 11
    single(1, 18'd16, 2'b11, 32'h0);
    single(0, 18'(NW*4), 2'b00, 32'h77);                // R7 out of range
    single(1, 18'(NW*4 + 4), 2'b00, 0);

    tag = "R6";
    single(0, 18'd16, 2'b00, 32'hDEAD_BEEF, 4'b1000);  // R6 bad parity enabled lane
    single(1, 18'd16, 2'b00, 0);
    single(0, 18'd16, 2'b01, 32'h5A00_0000, 4'b0001);  // R6 bad parity on unused lane
    single(0, 18'd17, 2'b01, 32'h0066_0000, 4'b0100);  // R6 bad parity on used lane
    single(1, 18'd16, 2'b00, 0);

    tag = "R8";
    single(0, 18'd20, 2'b00, 32'h0BAD_F00D, 4'h0, 1);  // R8 busy write retried
    single(1, 18'd20, 2'b11, 0, 4'h0, 1);              // R8 retry beats error
    single(1, 18'd20, 2'b00, 0);

    tag = "R9";
    burst(0, 18'd24, 2'b00, 5, 32'h1000_0001);          // R9 held past four beats
    burst(1, 18'd24, 2'b00, 3, 0);
    single(1, 18'd40, 2'b00, 0);

    tag = "R10";
    burst(0, 18'd32, 2'b00, 1, 32'h2000_0002);          // R10 abort after two beats
    burst(1, 18'd32, 2'b00, 3, 0);

    tag = "R11";
    burst(0, 18'd44, 2'b10, 2, 32'h3000_0003);          // R11 half-word burst
    burst(0, 18'((NW-2)*4), 2'b00, 3, 32'h4000_0004);   // R11 runs off the end
    burst(1, 18'((NW-2)*4), 2'b00, 3, 0);

    tag = "R12";
    burst(0, 18'd48, 2'b00, 3, 32'h5000_0005, 1);       // R12 start mid-burst
    single(1, 18'd0, 2'b00, 0);

    tag = "R4";
    for (int i = 0; i < NW; i++) single(1, 18'(i*4), 2'b00, 0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule